// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block keeps the per-line state of a bank of interrupt inputs and presents it to software through a 32-bit word-addressed register bus. For every line it holds an enable bit, a pending bit, an active bit, a group bit, an 8-bit priority, a CPU target mask and a trigger mode. It samples the interrupt lines on every clock and updates pending according to each line's trigger mode. It raises a request towards each CPU interface whenever an enabled, pending line targets that CPU and global forwarding is switched on.

A CPU interface reports the ID it has taken with an acknowledge strobe, and the ID it has finished with an end-of-interrupt strobe. These strobes move a line from pending to active and from active back to idle. The number of lines is `NUM_WORDS * 32`, and the number of CPU interfaces is `NUM_CPUS`, which is at most 8. Read data is combinational from the addressed state in the same cycle. Writes take effect at the clock edge.

Top module: `irqdist_top`

## Requirements
- R1: After a synchronous active-low reset, every enable, pending, active and group bit is 0, and every priority and target byte is 0. Forwarding is off, `cpu_irq` is 0, and every trigger bit reads 0 except those of IDs 0 to 15.
- R2: Writing 1 to bit b of the word at 0x100+4w enables line 32w+b, and writing 1 to the same bit at 0x180+4w disables it. Zero bits change nothing, and both words read back the current enable bits.
- R3: Pending is set through 0x200+4w and cleared through 0x280+4w. Active is set through 0x300+4w and cleared through 0x380+4w. Both pairs write and read like the enable pair.
- R4: The priority of line i is the byte at bits [8(i%4)+7 : 8(i%4)] of the word at 0x400+4(i/4). The full 8 bits are stored and read back.
- R5: The target mask of line i uses the same packing from 0x800. Bit c selects CPU c, and bits at or above `NUM_CPUS` are not stored and read 0.
- R6: In the word at 0xC00+4j, bit 2k+1 is the trigger mode of line 16j+k, where 1 means edge and 0 means level, and bit 2k reads 0. Word 0 (IDs 0 to 15) is fixed at edge, reads 0xAAAAAAAA and ignores writes.
- R7: Group bits are stored at 0x080+4w, one per line, and read back. They have no effect on forwarding.
- R8: The word at 0x004 reads `NUM_WORDS-1` in bits [4:0] and 0 elsewhere, and ignores writes. `NUM_WORDS` lies between 1 and 31, so the supported count stays below 1020.
- R9: Bit 0 of the word at 0x000 is the forwarding switch. `cpu_irq[c]` is 1 exactly when the switch is 1 and some line is enabled, pending and has target bit c set.
- R10: On a level line that is not active, pending takes the input level of the previous clock, unless a strobe or a pending write acts on it in that cycle. While the line is active, pending holds.
- R11: On an edge line, an input that is high in a cycle after being low in the cycle before sets pending. Pending then stays set until it is cleared or acknowledged.
- R12: An acknowledge for ID n (n < lines) clears pending and sets active. An end-of-interrupt clears active, and IDs at or above the line count are ignored. Per line, the precedence is: acknowledge, then end-of-interrupt, then bus clear, then bus set, then the input.
- R13: Addresses outside the map, and table words past the line count, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq_lines | input | NUM_WORDS*32 | Interrupt inputs, synchronous to `clk` |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 10 | ID being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | ID being completed |
| cpu_irq | output | NUM_CPUS | Request to each CPU interface |

## Verification
The bench builds the block with `NUM_WORDS=2` and `NUM_CPUS=4`. Two words exercise the decode of a second group, enable, pending and active word. They also exercise the split of word 0 between a read-only trigger half and a writable half, and they make IDs 64 and above real out-of-range strobes. Four CPUs leave target bits 4 to 7 unimplemented, so the bench can check that those bits read 0. A long stretch of random strobes, bus traffic and line toggling also produces same-cycle collisions between acknowledges, completions and pending writes.

// File: rtl/irqdist_pkg.sv
// Shared definitions for the interrupt distributor register bank.
package irqdist_pkg;
    localparam int ID_W = 10;

    // Register regions decoded from the bus address.
    typedef enum logic [3:0] {
        RG_NONE, RG_CTRL, RG_TYPE, RG_GRP,
        RG_EN_S, RG_EN_C, RG_PD_S, RG_PD_C, RG_AC_S, RG_AC_C,
        RG_PRI, RG_TGT, RG_CFG
    } region_e;
endpackage

// File: rtl/irqdist_decode.sv
// Address decoder: maps a byte address to a register region and a word
// index within it. Assumes word-aligned addresses; a table word past the
// configured line count decodes as RG_NONE.
module irqdist_decode
    import irqdist_pkg::*;
#(
    parameter int NUM_WORDS = 2
) (
    input  logic [11:0] addr,
    output region_e     region,
    output logic [9:0]  idx
);
    localparam int NUM_LINES = NUM_WORDS * 32;
    localparam int BYTE_WORDS = NUM_LINES / 4;
    localparam int CFG_WORDS = NUM_LINES / 16;

    logic word_ok;

    // Region and index selection.
    always_comb begin
        region  = RG_NONE;
        idx     = {5'd0, addr[6:2]};
        word_ok = int'(addr[6:2]) < NUM_WORDS;
        case (addr[11:10])
            2'b00: begin
                case (addr[9:7])
                    3'd0: begin
                        if (addr[6:2] == 5'd0) region = RG_CTRL;
                        else if (addr[6:2] == 5'd1) region = RG_TYPE;
                    end
                    3'd1: if (word_ok) region = RG_GRP;
                    3'd2: if (word_ok) region = RG_EN_S;
                    3'd3: if (word_ok) region = RG_EN_C;
                    3'd4: if (word_ok) region = RG_PD_S;
                    3'd5: if (word_ok) region = RG_PD_C;
                    3'd6: if (word_ok) region = RG_AC_S;
                    default: if (word_ok) region = RG_AC_C;
                endcase
            end
            2'b01: begin
                idx = {2'b00, addr[9:2]};
                if (int'(addr[9:2]) < BYTE_WORDS) region = RG_PRI;
            end
            2'b10: begin
                idx = {2'b00, addr[9:2]};
                if (int'(addr[9:2]) < BYTE_WORDS) region = RG_TGT;
            end
            default: begin
                idx = {2'b00, addr[9:2]};
                if (int'(addr[9:2]) < CFG_WORDS) region = RG_CFG;
            end
        endcase
    end
endmodule

// File: rtl/irqdist_word.sv
// State of 32 interrupt lines: enable, pending, active, group and trigger
// mode. Inputs are assumed synchronous to clk. Masks arrive pre-gated by the
// bus decode; strobe hits are one-hot or zero. With FIXED_LOW the lower 16
// lines are fixed edge-triggered.
module irqdist_word #(
    parameter bit FIXED_LOW = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] irq_in,
    input  logic [31:0] en_set,
    input  logic [31:0] en_clr,
    input  logic [31:0] pd_set,
    input  logic [31:0] pd_clr,
    input  logic [31:0] ac_set,
    input  logic [31:0] ac_clr,
    input  logic        grp_we,
    input  logic [1:0]  cfg_we,
    input  logic [31:0] wdata,
    input  logic [31:0] ack_hit,
    input  logic [31:0] eoi_hit,
    output logic [31:0] en_q,
    output logic [31:0] pend_q,
    output logic [31:0] act_q,
    output logic [31:0] grp_q,
    output logic [31:0] edge_q
);
    logic [31:0] irq_prev;
    logic [31:0] rise;
    logic [31:0] nxt_pend;
    logic [31:0] nxt_act;

    assign rise = irq_in & ~irq_prev;

    // Trigger mode storage, one half-word per configuration word.
    for (genvar h = 0; h < 2; h++) begin : g_cfg
        if (FIXED_LOW && h == 0) begin : g_fixed
            assign edge_q[15:0] = 16'hFFFF;
        end else begin : g_prog
            logic [15:0] cfg_half;
            // Capture the upper bit of each two-bit field on a write.
            always_ff @(posedge clk) begin
                if (!rst_n) cfg_half <= '0;
                else if (cfg_we[h])
                    for (int k = 0; k < 16; k++) cfg_half[k] <= wdata[2*k+1];
            end
            assign edge_q[16*h +: 16] = cfg_half;
        end
    end

    // Next active and pending, highest precedence first.
    always_comb begin
        nxt_act  = ack_hit | (~eoi_hit & ~ac_clr & (ac_set | act_q));
        nxt_pend = ~ack_hit & ~pd_clr &
                   (pd_set
                    | (edge_q & (rise | pend_q))
                    | (~edge_q & ((act_q & pend_q) | (~act_q & irq_in))));
    end

    // Line state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            pend_q   <= '0;
            act_q    <= '0;
            grp_q    <= '0;
            irq_prev <= '0;
        end else begin
            en_q     <= (en_q & ~en_clr) | en_set;
            pend_q   <= nxt_pend;
            act_q    <= nxt_act;
            irq_prev <= irq_in;
            if (grp_we) grp_q <= wdata;
        end
    end
endmodule

// File: rtl/irqdist_bytes.sv
// Byte-per-line field table (priority or target mask), four fields per bus
// word. Only the low BYTE_W bits of each byte lane are kept; BYTE_W <= 8.
module irqdist_bytes #(
    parameter int NUM_BWORDS = 16,
    parameter int BYTE_W     = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [9:0]                       idx,
    input  logic [31:0]                      wdata,
    output logic [31:0]                      rdata,
    output logic [NUM_BWORDS*4*BYTE_W-1:0]   flat
);
    localparam int NUM_FIELDS = NUM_BWORDS * 4;

    logic [BYTE_W-1:0] mem [NUM_FIELDS];

    // Field storage with word-wide writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_FIELDS; i++) mem[i] <= '0;
        end else if (we) begin
            for (int w = 0; w < NUM_BWORDS; w++)
                if (idx == 10'(w))
                    for (int b = 0; b < 4; b++)
                        mem[w*4+b] <= wdata[8*b +: BYTE_W];
        end
    end

    // Read word assembly, unused lane bits read 0.
    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_BWORDS; w++)
            if (idx == 10'(w))
                for (int b = 0; b < 4; b++)
                    rdata[8*b +: BYTE_W] = mem[w*4+b];
    end

    // Flattened view for the forwarding logic.
    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++) flat[i*BYTE_W +: BYTE_W] = mem[i];
    end
endmodule

// File: rtl/irqdist_fwd.sv
// Forwarding: one request per CPU, the OR of all live lines whose target
// mask selects that CPU, gated by the global switch. Purely combinational.
module irqdist_fwd #(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 8
) (
    input  logic                          fwd_en,
    input  logic [NUM_LINES-1:0]          live,
    input  logic [NUM_LINES*NUM_CPUS-1:0] tgt,
    output logic [NUM_CPUS-1:0]           cpu_irq
);
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic acc;
        // Reduce the live lines that target this CPU.
        always_comb begin
            acc = 1'b0;
            for (int i = 0; i < NUM_LINES; i++) acc = acc | (live[i] & tgt[i*NUM_CPUS+c]);
        end
        assign cpu_irq[c] = fwd_en & acc;
    end
endmodule

// File: rtl/irqdist_top.sv
// Interrupt distributor register bank. Holds per-line state behind a
// single-cycle register bus with combinational read data, samples the
// interrupt inputs (assumed synchronous) and forwards live lines to the CPU
// interfaces. NUM_WORDS in 1..31, NUM_CPUS in 1..8.
module irqdist_top
    import irqdist_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int NUM_CPUS  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic [11:0]             bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_WORDS*32-1:0] irq_lines,
    input  logic                    ack_valid,
    input  logic [9:0]              ack_id,
    input  logic                    eoi_valid,
    input  logic [9:0]              eoi_id,
    output logic [NUM_CPUS-1:0]     cpu_irq
);
    localparam int NUM_LINES = NUM_WORDS * 32;
    localparam int BYTE_WORDS = NUM_LINES / 4;
    localparam int CFG_WORDS = NUM_LINES / 16;

    region_e                      region;
    logic [9:0]                   idx;
    logic                         wr;
    logic                         ctrl_en;
    logic [NUM_LINES-1:0]         en_all, pend_all, act_all, grp_all, edge_all;
    logic [NUM_LINES*8-1:0]       pri_flat;
    logic [NUM_LINES*NUM_CPUS-1:0] tgt_flat;
    logic [31:0]                  pri_rdata, tgt_rdata;
    logic [31:0]                  en_rd, pend_rd, act_rd, grp_rd, cfg_rd;

    assign wr = bus_en & bus_we;

    irqdist_decode #(.NUM_WORDS(NUM_WORDS)) u_dec (
        .addr   (bus_addr),
        .region (region),
        .idx    (idx)
    );

    // Global forwarding switch.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_en <= 1'b0;
        else if (wr && region == RG_CTRL) ctrl_en <= bus_wdata[0];
    end

    // One state slice per 32 lines.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic        sel;
        logic [31:0] ack_hit, eoi_hit;
        logic [1:0]  cfg_we;

        assign sel     = wr && (idx == 10'(w));
        assign ack_hit = (ack_valid && ack_id[9:5] == 5'(w)) ? (32'd1 << ack_id[4:0]) : 32'd0;
        assign eoi_hit = (eoi_valid && eoi_id[9:5] == 5'(w)) ? (32'd1 << eoi_id[4:0]) : 32'd0;
        assign cfg_we  = {wr && region == RG_CFG && idx == 10'(2*w+1),
                          wr && region == RG_CFG && idx == 10'(2*w)};

        irqdist_word #(.FIXED_LOW(w == 0)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_in  (irq_lines[32*w +: 32]),
            .en_set  ((sel && region == RG_EN_S) ? bus_wdata : 32'd0),
            .en_clr  ((sel && region == RG_EN_C) ? bus_wdata : 32'd0),
            .pd_set  ((sel && region == RG_PD_S) ? bus_wdata : 32'd0),
            .pd_clr  ((sel && region == RG_PD_C) ? bus_wdata : 32'd0),
            .ac_set  ((sel && region == RG_AC_S) ? bus_wdata : 32'd0),
            .ac_clr  ((sel && region == RG_AC_C) ? bus_wdata : 32'd0),
            .grp_we  (sel && region == RG_GRP),
            .cfg_we  (cfg_we),
            .wdata   (bus_wdata),
            .ack_hit (ack_hit),
            .eoi_hit (eoi_hit),
            .en_q    (en_all[32*w +: 32]),
            .pend_q  (pend_all[32*w +: 32]),
            .act_q   (act_all[32*w +: 32]),
            .grp_q   (grp_all[32*w +: 32]),
            .edge_q  (edge_all[32*w +: 32])
        );
    end

    irqdist_bytes #(.NUM_BWORDS(BYTE_WORDS), .BYTE_W(8)) u_pri (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr && region == RG_PRI),
        .idx   (idx),
        .wdata (bus_wdata),
        .rdata (pri_rdata),
        .flat  (pri_flat)
    );

    irqdist_bytes #(.NUM_BWORDS(BYTE_WORDS), .BYTE_W(NUM_CPUS)) u_tgt (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr && region == RG_TGT),
        .idx   (idx),
        .wdata (bus_wdata),
        .rdata (tgt_rdata),
        .flat  (tgt_flat)
    );

    irqdist_fwd #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) u_fwd (
        .fwd_en  (ctrl_en),
        .live    (en_all & pend_all),
        .tgt     (tgt_flat),
        .cpu_irq (cpu_irq)
    );

    // Select the addressed 32-line word of each bit table.
    always_comb begin
        en_rd = '0; pend_rd = '0; act_rd = '0; grp_rd = '0; cfg_rd = '0;
        for (int w = 0; w < NUM_WORDS; w++)
            if (idx == 10'(w)) begin
                en_rd   = en_all[32*w +: 32];
                pend_rd = pend_all[32*w +: 32];
                act_rd  = act_all[32*w +: 32];
                grp_rd  = grp_all[32*w +: 32];
            end
        for (int j = 0; j < CFG_WORDS; j++)
            if (idx == 10'(j))
                for (int k = 0; k < 16; k++) cfg_rd[2*k+1] = edge_all[16*j+k];
    end

    // Read data multiplexer.
    always_comb begin
        case (region)
            RG_CTRL:         bus_rdata = {31'd0, ctrl_en};
            RG_TYPE:         bus_rdata = 32'(NUM_WORDS - 1);
            RG_GRP:          bus_rdata = grp_rd;
            RG_EN_S, RG_EN_C: bus_rdata = en_rd;
            RG_PD_S, RG_PD_C: bus_rdata = pend_rd;
            RG_AC_S, RG_AC_C: bus_rdata = act_rd;
            RG_PRI:          bus_rdata = pri_rdata;
            RG_TGT:          bus_rdata = tgt_rdata;
            RG_CFG:          bus_rdata = cfg_rd;
            default:         bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqdist_checker.sv
// Property checker for irqdist_top, attached by bind. Looks up the state of
// the line named by the previous cycle's strobes.
module irqdist_checker #(
    parameter int NUM_WORDS = 2,
    parameter int NUM_CPUS  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_en,
    input logic                    bus_we,
    input logic [11:0]             bus_addr,
    input logic [31:0]             bus_rdata,
    input logic                    ack_valid,
    input logic [9:0]              ack_id,
    input logic                    eoi_valid,
    input logic [9:0]              eoi_id,
    input logic [NUM_CPUS-1:0]     cpu_irq,
    input logic                    ctrl_en,
    input logic [NUM_WORDS*32-1:0] en_all,
    input logic [NUM_WORDS*32-1:0] pend_all,
    input logic [NUM_WORDS*32-1:0] act_all
);
    localparam int NUM_LINES = NUM_WORDS * 32;

    logic [9:0] ack_id_q, eoi_id_q;
    logic       act_at_ack, pend_at_ack, act_at_eoi;

    // Remember the strobe IDs of the previous cycle.
    always_ff @(posedge clk) begin
        ack_id_q <= ack_id;
        eoi_id_q <= eoi_id;
    end

    // Look up the current state of those lines.
    always_comb begin
        act_at_ack = 1'b0; pend_at_ack = 1'b0; act_at_eoi = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (ack_id_q == 10'(i)) begin
                act_at_ack  = act_all[i];
                pend_at_ack = pend_all[i];
            end
            if (eoi_id_q == 10'(i)) act_at_eoi = act_all[i];
        end
    end

    assert_ack_activates_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id < 10'(NUM_LINES)) |=> (act_at_ack && !pend_at_ack));

    assert_eoi_deactivates_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_id < 10'(NUM_LINES) && !(ack_valid && ack_id == eoi_id))
        |=> !act_at_eoi);

    assert_switch_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (cpu_irq == '0));

    assert_needs_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_all & pend_all) == '0) |-> (cpu_irq == '0));

    assert_type_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr[11:2] == 10'd1) |-> (bus_rdata == 32'(NUM_WORDS - 1)));

    assert_hole_reads_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr[11:2] == 10'd2) |-> (bus_rdata == 32'd0));
endmodule

bind irqdist_top irqdist_checker #(.NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ack_valid (ack_valid),
    .ack_id    (ack_id),
    .eoi_valid (eoi_valid),
    .eoi_id    (eoi_id),
    .cpu_irq   (cpu_irq),
    .ctrl_en   (ctrl_en),
    .en_all    (en_all),
    .pend_all  (pend_all),
    .act_all   (act_all)
);

// File: tb/irqdist_top_tb.sv
`timescale 1ns/1ps
// Bench for irqdist_top with a behavioural reference model compared on
// every clock.
module irqdist_top_tb;
    localparam int NW = 2;
    localparam int NC = 4;
    localparam int NL = NW * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] irq = '0;
    logic          ack_valid = 1'b0, eoi_valid = 1'b0;
    logic [9:0]    ack_id = '0, eoi_id = '0;
    logic [NC-1:0] cpu_irq;

    int vectors = 0;
    int fails = 0;
    string rd_tag = "";

    // Reference model state.
    logic [NL-1:0] m_en = '0, m_pd = '0, m_ac = '0, m_gr = '0, m_prev = '0;
    logic [NL-1:0] m_edge = NL'(64'hFFFF);
    int            m_pri [NL];
    int            m_tgt [NL];
    logic          m_ctrl = 1'b0;

    always #4 clk = ~clk;

    irqdist_top #(.NUM_WORDS(NW), .NUM_CPUS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq), .ack_valid(ack_valid), .ack_id(ack_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id), .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] exp_read(input int a);
        logic [31:0] r = '0;
        int wi = (a >> 2) & 31;
        int blk = a >> 7;
        if (a == 0) r = {31'd0, m_ctrl};
        else if (a == 4) r = 32'(NW - 1);
        else if (a < 'h400 && blk >= 1 && wi < NW) begin
            case (blk)
                1: r = m_gr[32*wi +: 32];
                2, 3: r = m_en[32*wi +: 32];
                4, 5: r = m_pd[32*wi +: 32];
                default: r = m_ac[32*wi +: 32];
            endcase
        end else if (a >= 'h400 && a < 'h800) begin
            int k = (a - 'h400) >> 2;
            if (k < NL/4) for (int b = 0; b < 4; b++) r[8*b +: 8] = 8'(m_pri[4*k+b]);
        end else if (a >= 'h800 && a < 'hC00) begin
            int k = (a - 'h800) >> 2;
            if (k < NL/4) for (int b = 0; b < 4; b++) r[8*b +: 8] = 8'(m_tgt[4*k+b]);
        end else if (a >= 'hC00) begin
            int j = (a - 'hC00) >> 2;
            if (j < NL/16) for (int k = 0; k < 16; k++) r[2*k+1] = m_edge[16*j+k];
        end
        return r;
    endfunction

    function automatic logic [NC-1:0] exp_cpu();
        logic [NC-1:0] r = '0;
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < NL; i++)
                if (m_ctrl && m_en[i] && m_pd[i] && ((m_tgt[i] >> c) & 1) == 1) r[c] = 1'b1;
        return r;
    endfunction

    task automatic model_update();
        logic [NL-1:0] s_en = '0, c_en = '0, s_pd = '0, c_pd = '0, s_ac = '0, c_ac = '0;
        logic [NL-1:0] ah = '0, eh = '0, n_pd, n_ac;
        int a = int'(bus_addr);
        int wi = (a >> 2) & 31;
        int blk = a >> 7;
        if (ack_valid && ack_id < NL) ah[ack_id] = 1'b1;
        if (eoi_valid && eoi_id < NL) eh[eoi_id] = 1'b1;
        if (bus_en && bus_we && a < 'h400 && blk >= 1 && wi < NW) begin
            case (blk)
                1: m_gr[32*wi +: 32] = bus_wdata;
                2: s_en[32*wi +: 32] = bus_wdata;
                3: c_en[32*wi +: 32] = bus_wdata;
                4: s_pd[32*wi +: 32] = bus_wdata;
                5: c_pd[32*wi +: 32] = bus_wdata;
                6: s_ac[32*wi +: 32] = bus_wdata;
                default: c_ac[32*wi +: 32] = bus_wdata;
            endcase
        end
        for (int i = 0; i < NL; i++) begin
            n_ac[i] = ah[i] ? 1'b1 : eh[i] ? 1'b0 : c_ac[i] ? 1'b0 : s_ac[i] ? 1'b1 : m_ac[i];
            if (ah[i] || c_pd[i]) n_pd[i] = 1'b0;
            else if (s_pd[i]) n_pd[i] = 1'b1;
            else if (m_edge[i]) n_pd[i] = m_pd[i] | (irq[i] & ~m_prev[i]);
            else n_pd[i] = m_ac[i] ? m_pd[i] : irq[i];
        end
        m_pd = n_pd;
        m_ac = n_ac;
        m_en = (m_en & ~c_en) | s_en;
        m_prev = irq;
        if (bus_en && bus_we) begin
            if (a == 0) m_ctrl = bus_wdata[0];
            else if (a >= 'h400 && a < 'h800) begin
                int k = (a - 'h400) >> 2;
                if (k < NL/4) for (int b = 0; b < 4; b++) m_pri[4*k+b] = int'(bus_wdata[8*b +: 8]);
            end else if (a >= 'h800 && a < 'hC00) begin
                int k = (a - 'h800) >> 2;
                if (k < NL/4)
                    for (int b = 0; b < 4; b++) m_tgt[4*k+b] = int'(bus_wdata[8*b +: 8]) & ((1 << NC) - 1);
            end else if (a >= 'hC00) begin
                int j = (a - 'hC00) >> 2;
                if (j >= 1 && j < NL/16) for (int k = 0; k < 16; k++) m_edge[16*j+k] = bus_wdata[2*k+1];
            end
        end
    endtask

    // One clock: compare before the edge, advance the model after it.
    task automatic step();
        logic [31:0] er;
        logic [NC-1:0] ec;
        #3;
        ec = exp_cpu();
        vectors++;
        if (cpu_irq !== ec) begin
            fails++;
            $display("FAIL R9 cpu_irq: actual %h expected %h at %0t", cpu_irq, ec, $time);
        end
        if (bus_en && !bus_we) begin
            er = exp_read(int'(bus_addr));
            vectors++;
            if (bus_rdata !== er) begin
                fails++;
                $display("FAIL %s read %h: actual %h expected %h", rd_tag, bus_addr, bus_rdata, er);
            end
        end
        @(posedge clk);
        #1 model_update();
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; ack_valid = 1'b0; eoi_valid = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a[11:0]; bus_wdata = d;
        step();
    endtask

    task automatic rd(input int a, input string t);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a[11:0]; rd_tag = t;
        step();
    endtask

    task automatic do_ack(input int id);
        ack_valid = 1'b1; ack_id = id[9:0];
        step();
    endtask

    task automatic do_eoi(input int id);
        eoi_valid = 1'b1; eoi_id = id[9:0];
        step();
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) begin m_pri[i] = 0; m_tgt[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd('h000, "R1"); rd('h100, "R1"); rd('h204, "R1"); rd('h300, "R1");
        rd('h400, "R1"); rd('h800, "R1"); rd('hC00, "R1"); rd('hC04, "R1"); rd('h080, "R1");
        rd('h004, "R8");

        // R2 enable pair
        wr('h100, 32'h0000_00F0); wr('h100, 32'h0); rd('h100, "R2");
        wr('h180, 32'h0000_0030); rd('h180, "R2");
        wr('h104, 32'h8000_0001); rd('h104, "R2"); rd('h100, "R2");

        // R4 priority packing, R13 table past the end
        wr('h400, 32'h1122_3344); wr('h43C, 32'hA0B0_C0D0);
        rd('h400, "R4"); rd('h43C, "R4"); rd('h440, "R13");
        wr('h440, 32'hFFFF_FFFF); rd('h440, "R13");

        // R5 target packing and unimplemented CPU bits
        wr('h800, 32'hFFFF_FF0F); rd('h800, "R5");
        wr('h814, 32'h0102_0408); rd('h814, "R5");

        // R6 trigger configuration
        wr('hC00, 32'h5555_5555); rd('hC00, "R6");
        wr('hC04, 32'h0000_000A); rd('hC04, "R6");
        wr('hC08, 32'hFFFF_FFFF); rd('hC08, "R6"); rd('hC10, "R13");

        // R7 group bits
        wr('h080, 32'hDEAD_BEEF); rd('h080, "R7");
        wr('h084, 32'h0004_0000); rd('h084, "R7");

        // R9 / R10 level line 50 targeting CPU 1
        wr('h000, 32'h1); rd('h000, "R9");
        wr('h830, 32'h0002_0000); wr('h104, 32'h0004_0000);
        irq[50] = 1'b1; step(); rd('h204, "R10");
        irq[50] = 1'b0; step(); rd('h204, "R10");

        // R11 edge line 40 targeting CPU 2
        wr('h828, 32'h0000_0004); wr('h104, 32'h0000_0100);
        irq[40] = 1'b1; step(); irq[40] = 1'b0; step(); step();
        rd('h204, "R11");
        irq[40] = 1'b1; step(); step(); rd('h204, "R11");
        irq[40] = 1'b0;

        // R12 acknowledge and completion
        do_ack(40); rd('h204, "R12"); rd('h304, "R12");
        do_eoi(40); rd('h304, "R12");
        irq[50] = 1'b1; step(); do_ack(50); step(); rd('h204, "R10"); rd('h304, "R12");
        do_eoi(50); step(); rd('h204, "R10");
        irq[50] = 1'b0; step();
        do_ack(100); rd('h300, "R12"); rd('h304, "R12");
        ack_valid = 1'b1; ack_id = 10'd40; eoi_valid = 1'b1; eoi_id = 10'd40; step();
        rd('h304, "R12");

        // R3 pending and active pairs
        wr('h200, 32'h0000_0011); rd('h200, "R3"); wr('h280, 32'h0000_0001); rd('h280, "R3");
        wr('h300, 32'h0000_0F00); rd('h300, "R3"); wr('h380, 32'h0000_0300); rd('h380, "R3");
        wr('h100, 32'h0000_0010); wr('h810, 32'h0000_0003); step();

        // R9 switch off, R13 / R8 ignored writes
        wr('h000, 32'h0); step(); rd('h000, "R9");
        wr('h008, 32'hFFFF_FFFF); rd('h008, "R13");
        wr('h004, 32'hFFFF_FFFF); rd('h004, "R8");
        wr('h000, 32'h1);

        // Random traffic on all requirements
        for (int n = 0; n < 3000; n++) begin
            int op = int'($urandom % 8);
            int sel = int'($urandom % 12);
            int addrs [12] = '{'h000, 'h084, 'h100, 'h184, 'h204, 'h280,
                               'h304, 'h380, 'h80C, 'h838, 'hC04, 'hC0C};
            irq = {$urandom, $urandom};
            case (op)
                0, 1: wr(addrs[sel], $urandom);
                2, 3: rd(addrs[sel], "R12");
                4: do_ack(int'($urandom % 80));
                5: do_eoi(int'($urandom % 80));
                6: begin
                    ack_valid = 1'b1; ack_id = 10'($urandom % 70);
                    eoi_valid = 1'b1; eoi_id = 10'($urandom % 70);
                    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'(addrs[sel]); bus_wdata = $urandom;
                    step();
                end
                default: step();
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule